// File: doc/BRIEF.md
# Gapless Ping-Pong Parallel Word Streamer

This block produces a continuous stream of 16-bit parallel words, with an accompanying output clock, from two buffer channels that it reads in turn. It reads a fixed number of words from one channel, then moves to the other, and keeps alternating. The move is triggered by a word counter reaching the buffer size. The machine does not wait for the active channel's ready flag to drop, so in the default mode the stream runs across a buffer change with no idle cycle.

Each channel presents its head word together with a ready flag. The block answers with a one-cycle pop strobe for every word it takes, so the buffer logic can advance its read pointer. A mode input can place a check state between the two channels. In that mode the machine waits until the next channel reports ready before it drives from it. This costs at least one idle output cycle at each change. In the default mode, a channel that is not ready when it is due raises a sticky underrun flag, and the output valid drops until data returns.

Top module: `pingpong_streamer`

## Requirements
- R1: After a synchronous active-high reset the block is idle: `out_valid` and `underrun` are 0 and neither pop strobe is asserted.
- R2: Streaming starts only while `enable` is 1 and channel 0 is ready. The first word of every stream comes from channel 0, and channel 1's ready flag has no effect on the start.
- R3: Each word taken produces exactly one single-cycle pop on the active channel. The two pops are never asserted together.
- R4: A word popped in one cycle appears on `out_data` with `out_valid` = 1 after the next rising `clk` edge, and `out_valid` is 0 in the cycle after any cycle without a pop. `out_clk` is the inverse of `clk`, so its rising edge falls in the middle of each word.
- R5: After exactly `BUF_WORDS` pops from one channel the block switches to the other channel, with strict alternation 0, 1, 0, … The word counter restarts from zero at each switch.
- R6: With `check_mode` = 0 and the next channel ready, the first word of the next channel directly follows the last word of the previous one, with no cycle where `out_valid` is 0.
- R7: With `check_mode` = 1, the block goes through a check state after each switch. It pops nothing there and waits until the next channel is ready, so there is at least one cycle with `out_valid` = 0 between the two channels.
- R8: If the active channel is not ready during a drive cycle, the block does not pop, `out_valid` is 0 in the following cycle and `underrun` becomes 1. Only reset clears `underrun`. Driving resumes on the same channel, and the words already counted are kept.
- R9: When `enable` is 0, no pop is issued. The block returns to idle with the counter cleared, and the next stream starts again from channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows streaming |
| check_mode | input | 1 | 1 places a readiness check state between channels |
| ch0_data | input | 16 | Head word of channel 0 |
| ch0_ready | input | 1 | Channel 0 has a word available |
| ch0_pop | output | 1 | Takes the head word of channel 0 |
| ch1_data | input | 16 | Head word of channel 1 |
| ch1_ready | input | 1 | Channel 1 has a word available |
| ch1_pop | output | 1 | Takes the head word of channel 1 |
| out_data | output | 16 | Parallel output word |
| out_clk | output | 1 | Output clock, inverse of `clk` |
| out_valid | output | 1 | `out_data` holds a streamed word |
| underrun | output | 1 | Sticky: the active channel was not ready when due |

## Verification
The bench uses a small buffer size. It watches the channel changes for a counter that is off by one: such a design would hand over after `BUF_WORDS`±1 words or would fail to restart its count. In the default mode, a design that ends a drive on the ready flag, or that inserts a state, would show a valid-low cycle at the seam. In the check mode, a design that skips the check state would show no gap. Ready patterns that toggle in the middle of a buffer reveal several faults: pops issued to a channel that is not ready, words that are lost or repeated, an underrun flag that is not sticky, and a count that is lost across a stall. Dropping `enable` in the middle of a buffer shows whether a restart wrongly resumes on channel 1.

// File: rtl/ps_pkg.sv
package ps_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRIVE = 2'd1,
    ST_CHECK = 2'd2
  } ps_state_e;

  // True when a word count sits on the last word of a buffer.
  function automatic logic hit_last(input int unsigned cnt, input int unsigned words);
    return cnt == (words - 1);
  endfunction

endpackage

// File: rtl/ps_word_counter.sv
module ps_word_counter #(
  parameter int WORDS = 8192,
  localparam int CW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          step,
  output logic [CW-1:0] count,
  output logic          last
);

  assign last = ps_pkg::hit_last(32'(count), WORDS);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      count <= '0;
    end else if (step) begin
      count <= last ? '0 : count + 1'b1;
    end
  end

endmodule

// File: rtl/ps_ctrl.sv
module ps_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic check_mode,
  input  logic rdy0,
  input  logic rdy1,
  input  logic last,
  output logic pop0,
  output logic pop1,
  output logic step,
  output logic wrap,
  output logic starve,
  output logic clear,
  output logic active_ch,
  output logic underrun
);
  import ps_pkg::*;

  ps_state_e st;
  logic      rdy_act;
  logic      driving;

  assign rdy_act = active_ch ? rdy1 : rdy0;
  assign driving = enable && (st == ST_DRIVE);
  assign step    = driving && rdy_act;
  assign starve  = driving && !rdy_act;
  assign pop0    = step && !active_ch;
  assign pop1    = step && active_ch;
  assign wrap    = step && last;
  assign clear   = !enable;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      active_ch <= 1'b0;
      underrun  <= 1'b0;
    end else begin
      if (starve) underrun <= 1'b1;
      if (!enable) begin
        st        <= ST_IDLE;
        active_ch <= 1'b0;
      end else begin
        case (st)
          ST_IDLE: if (rdy0) begin
            st        <= ST_DRIVE;
            active_ch <= 1'b0;
          end
          ST_DRIVE: if (wrap) begin
            active_ch <= ~active_ch;
            st        <= check_mode ? ST_CHECK : ST_DRIVE;
          end
          ST_CHECK: if (rdy_act) st <= ST_DRIVE;
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/ps_out_stage.sv
module ps_out_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         sel,
  input  logic [W-1:0] d0,
  input  logic [W-1:0] d1,
  output logic [W-1:0] data,
  output logic         valid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
    end else begin
      valid <= step;
      if (step) data <= sel ? d1 : d0;
    end
  end

endmodule

// File: rtl/pingpong_streamer.sv
module pingpong_streamer #(
  parameter int DATA_W    = 16,
  parameter int BUF_WORDS = 8192,
  localparam int CW = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              check_mode,
  input  logic [DATA_W-1:0] ch0_data,
  input  logic              ch0_ready,
  output logic              ch0_pop,
  input  logic [DATA_W-1:0] ch1_data,
  input  logic              ch1_ready,
  output logic              ch1_pop,
  output logic [DATA_W-1:0] out_data,
  output logic              out_clk,
  output logic              out_valid,
  output logic              underrun
);

  // Named internal events, visible to the checker
  logic          step_evt;
  logic          wrap_evt;
  logic          starve_evt;
  logic          clear_evt;
  logic          last_word;
  logic          active_ch;
  logic [CW-1:0] word_count;

  ps_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .check_mode (check_mode),
    .rdy0       (ch0_ready),
    .rdy1       (ch1_ready),
    .last       (last_word),
    .pop0       (ch0_pop),
    .pop1       (ch1_pop),
    .step       (step_evt),
    .wrap       (wrap_evt),
    .starve     (starve_evt),
    .clear      (clear_evt),
    .active_ch  (active_ch),
    .underrun   (underrun)
  );

  ps_word_counter #(.WORDS(BUF_WORDS)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clear (clear_evt),
    .step  (step_evt),
    .count (word_count),
    .last  (last_word)
  );

  ps_out_stage #(.W(DATA_W)) u_out (
    .clk   (clk),
    .rst   (rst),
    .step  (step_evt),
    .sel   (active_ch),
    .d0    (ch0_data),
    .d1    (ch1_data),
    .data  (out_data),
    .valid (out_valid)
  );

  assign out_clk = ~clk;

endmodule

// File: rtl/ps_checker.sv
module ps_checker #(
  parameter int DATA_W    = 16,
  parameter int BUF_WORDS = 8192,
  parameter int CW        = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic              pop0,
  input logic              pop1,
  input logic [DATA_W-1:0] d0,
  input logic [DATA_W-1:0] d1,
  input logic [DATA_W-1:0] out_data,
  input logic              out_valid,
  input logic              underrun,
  input logic              starve,
  input logic              wrap,
  input logic              active_ch,
  input logic [CW-1:0]     count
);

  p_pop_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
    !(pop0 && pop1));

  p_valid_after_pop_r4: assert property (@(posedge clk) disable iff (rst)
    (pop0 || pop1) |=> out_valid);

  p_idle_after_nopop_r4: assert property (@(posedge clk) disable iff (rst)
    !(pop0 || pop1) |=> !out_valid);

  p_data_ch0_r4: assert property (@(posedge clk) disable iff (rst)
    pop0 |=> out_data == $past(d0));

  p_data_ch1_r4: assert property (@(posedge clk) disable iff (rst)
    pop1 |=> out_data == $past(d1));

  p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
    32'(count) < BUF_WORDS);

  p_alternate_r5: assert property (@(posedge clk) disable iff (rst)
    wrap |=> active_ch != $past(active_ch));

  p_starve_flags_r8: assert property (@(posedge clk) disable iff (rst)
    starve |=> underrun);

  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    underrun |=> underrun);

  p_no_pop_disabled_r9: assert property (@(posedge clk) disable iff (rst)
    !enable |-> !(pop0 || pop1));

endmodule

bind pingpong_streamer ps_checker #(
  .DATA_W(DATA_W), .BUF_WORDS(BUF_WORDS), .CW(CW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .enable    (enable),
  .pop0      (ch0_pop),
  .pop1      (ch1_pop),
  .d0        (ch0_data),
  .d1        (ch1_data),
  .out_data  (out_data),
  .out_valid (out_valid),
  .underrun  (underrun),
  .starve    (starve_evt),
  .wrap      (wrap_evt),
  .active_ch (active_ch),
  .count     (word_count)
);

// File: tb/pingpong_streamer_test.sv
module pingpong_streamer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 8;

  logic clk = 1'b0, rst = 1'b1, enable = 1'b0, check_mode = 1'b0;
  logic rdy0 = 1'b0, rdy1 = 1'b0;
  int   rd0 = 0, rd1 = 0;
  wire  [15:0] d0 = 16'(rd0);
  wire  [15:0] d1 = 16'h8000 | 16'(rd1 & 32'h7fff);
  logic [15:0] out_data;
  logic out_clk, out_valid, underrun, pop0, pop1;

  int n_chk = 0, n_err = 0;

  pingpong_streamer #(.DATA_W(16), .BUF_WORDS(NW)) uut (
    .clk(clk), .rst(rst), .enable(enable), .check_mode(check_mode),
    .ch0_data(d0), .ch0_ready(rdy0), .ch0_pop(pop0),
    .ch1_data(d1), .ch1_ready(rdy1), .ch1_pop(pop1),
    .out_data(out_data), .out_clk(out_clk), .out_valid(out_valid),
    .underrun(underrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model: 0 idle, 1 drive, 2 check
  int   m_st = 0, m_cnt = 0;
  bit   m_ch = 0, m_valid = 0, m_under = 0, m_r;
  logic [15:0] m_data = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_ch = 0; m_cnt = 0; m_valid = 0; m_under = 0;
    end else begin
      m_r = m_ch ? rdy1 : rdy0;
      if (m_st == 1 && enable && !m_r) m_under = 1;
      m_valid = 0;
      if (!enable) begin
        m_st = 0; m_ch = 0; m_cnt = 0;
      end else if (m_st == 0) begin
        if (rdy0) begin m_st = 1; m_ch = 0; end
      end else if (m_st == 1) begin
        if (m_r) begin
          m_valid = 1;
          m_data = m_ch ? d1 : d0;
          if (m_ch) rd1 <= rd1 + 1; else rd0 <= rd0 + 1;
          if (m_cnt == NW - 1) begin
            m_cnt = 0; m_ch = !m_ch;
            if (check_mode) m_st = 2;
          end else m_cnt++;
        end
      end else begin
        if (m_r) m_st = 1;
      end
    end
  end

  // Seam tracker and per-cycle comparison, away from the active edge
  bit started = 0, last_src = 0, expect_gapless = 0;
  int run = 0, gap = 0;

  always @(negedge clk) begin
    if (!rst) begin
      chk(out_valid == m_valid, "R4/R8 valid", 32'(out_valid), 32'(m_valid));
      if (m_valid) chk(out_data == m_data, "R4 data", 32'(out_data), 32'(m_data));
      chk(pop0 == (enable && m_st == 1 && !m_ch && rdy0), "R3 pop0", 32'(pop0), 32'(enable && m_st == 1 && !m_ch && rdy0));
      chk(pop1 == (enable && m_st == 1 && m_ch && rdy1), "R3 pop1", 32'(pop1), 32'(enable && m_st == 1 && m_ch && rdy1));
      chk(underrun == m_under, "R8 underrun", 32'(underrun), 32'(m_under));
      chk(out_clk == 1'b1, "R4 out_clk", 32'(out_clk), 32'd1);
    end
    if (rst || !enable) begin
      started = 0; run = 0; gap = 0;
    end else if (out_valid) begin
      if (!started) begin
        chk(out_data[15] == 1'b0, "R2 first channel", 32'(out_data[15]), 32'd0);
        started = 1; run = 1;
      end else if (out_data[15] != last_src) begin
        chk(run == NW, "R5 words per buffer", 32'(run), 32'(NW));
        if (!check_mode && expect_gapless) chk(gap == 0, "R6 seam gap", 32'(gap), 32'd0);
        if (check_mode) chk(gap >= 1, "R7 check gap", 32'(gap), 32'd1);
        run = 1;
      end else run++;
      last_src = out_data[15];
      gap = 0;
    end else if (started) gap++;
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1: idle after reset
    chk(out_valid == 0 && underrun == 0 && !pop0 && !pop1, "R1 reset state",
        {out_valid, underrun, pop0, pop1}, 32'd0);

    // R2: channel 1 ready alone does not start the stream
    enable = 1'b1; rdy1 = 1'b1;
    cyc(4);
    chk(out_valid == 0 && !pop0 && !pop1, "R2 no start without ch0", 32'(out_valid), 32'd0);

    // R5/R6: both ready, default mode, seamless seams
    rdy0 = 1'b1; expect_gapless = 1;
    cyc(5 * NW);
    expect_gapless = 0;
    chk(underrun == 0, "R6 no underrun when ready", 32'(underrun), 32'd0);

    // R8: toggling readiness in default mode
    for (int i = 0; i < 60; i++) begin
      rdy0 = (i % 7) != 3;
      rdy1 = (i % 5) != 2;
      cyc(1);
    end
    chk(underrun == 1, "R8 underrun sticky", 32'(underrun), 32'd1);
    rdy0 = 1'b1; rdy1 = 1'b1;

    // R9: disable mid-stream, then restart on channel 0
    enable = 1'b0;
    cyc(3);
    chk(!pop0 && !pop1 && !out_valid, "R9 disabled", {pop0, pop1, out_valid}, 32'd0);
    chk(underrun == 1, "R8 sticky across disable", 32'(underrun), 32'd1);
    enable = 1'b1;
    cyc(3 * NW + 3);
    enable = 1'b0;
    cyc(2);

    // R7: check mode with readiness toggling
    rst = 1'b1;
    cyc(2);
    rst = 1'b0; check_mode = 1'b1; enable = 1'b1;
    cyc(1);
    chk(underrun == 0, "R1 underrun cleared by reset", 32'(underrun), 32'd0);
    for (int i = 0; i < 80; i++) begin
      rdy0 = (i % 6) != 1;
      rdy1 = (i % 9) < 5;
      cyc(1);
    end
    rdy0 = 1'b1; rdy1 = 1'b0;
    cyc(3 * NW);
    rdy1 = 1'b1;
    cyc(4 * NW);

    // R9: mid-buffer disable in check mode, restart from channel 0
    enable = 1'b0;
    cyc(2);
    enable = 1'b1;
    cyc(2 * NW + 4);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule